// File: doc/BRIEF.md
# UART Transmit Byte Queue with Watermark Status

This block sits between the register interface of a serial port and its bit-serial transmitter. Each write strobe offers one byte. While the queue has room the byte is stored in a circular buffer. The transmitter sees the oldest stored byte and a valid flag, and takes the byte with a one-cycle pop strobe. A soft-clear input empties the queue at once, whatever it holds.

Alongside the data path the block keeps the fill level and three flags: full, empty and watermark. A 2-bit selector sets the watermark threshold. The block also gives single-cycle pulses on three events: the watermark flag rising, the queue becoming empty, and a write dropped because the queue was full. An interrupt block that lies outside this design consumes these pulses.

Top module: `uart_tx_queue`

## Requirements
- R1: Bytes leave `popData` in the order they were accepted. `popValid` is high exactly when the level is non-zero. A cycle with `txPop` and `popValid` both high removes the head byte.
- R2: `fillLevel` rises by one after an accepted write and falls by one after a pop. It is unchanged when both happen in the same cycle. The new value is visible in the cycle after the clock edge.
- R3: `fullFlag` is high exactly when the level equals the depth (32 by default). It falls in the cycle after the first pop from a full queue.
- R4: `emptyFlag` is high exactly when the level is zero. `emptyEvent` pulses for one cycle, in the first cycle the level reads zero after it was non-zero. This applies whether the level reached zero by a pop or by a soft clear.
- R5: A write strobe while `fullFlag` is high is discarded. It leaves the level and the stored bytes unchanged, and `overflowPulse` is high for exactly the following cycle. This holds even when a pop happens in the same cycle.
- R6: `wmSel` codes 0, 1, 2 and 3 select thresholds of 1, 4, 8 and 16 bytes. An accepted write that brings the level to or above the threshold sets `wmFlag` in the next cycle. `wmEvent` pulses for one cycle when `wmFlag` rises.
- R7: `wmFlag` clears only when a pop or a soft clear drops the level below the selected threshold. A change of `wmSel` with no write, pop or clear leaves `wmFlag` unchanged.
- R8: `softClear` empties the queue by the next cycle and returns both buffer positions to their start. It also clears `wmFlag`. A write or pop offered in the same cycle is ignored.
- R9: After reset the level is 0, `emptyFlag` is 1, `popValid` is 0, and `fullFlag`, `wmFlag` and all event pulses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStrobe | input | 1 | Offer one byte to the queue |
| wrByte | input | 8 | Byte offered with `wrStrobe` |
| txPop | input | 1 | Transmitter takes the head byte |
| softClear | input | 1 | Empty the queue |
| wmSel | input | 2 | Watermark threshold select |
| popData | output | 8 | Head byte of the queue |
| popValid | output | 1 | Queue holds at least one byte |
| fillLevel | output | 6 | Number of stored bytes |
| fullFlag | output | 1 | Queue is full |
| emptyFlag | output | 1 | Queue is empty |
| wmFlag | output | 1 | Watermark reached |
| wmEvent | output | 1 | One-cycle pulse when `wmFlag` rises |
| emptyEvent | output | 1 | One-cycle pulse when the queue becomes empty |
| overflowPulse | output | 1 | One-cycle pulse for a dropped write |

## Verification
A pointer that drifts from the count shows up at the next pop: `popData` is then out of order or stale, and the scoreboard catches this in that same cycle. A flag register that disagrees with the level is visible one cycle after the edge that caused the error, because every step compares each flag with a level model the bench keeps itself. A watermark that follows the selector through logic, rather than through events, fails the check made right after `wmSel` changes on an idle cycle. A write leaking through while the queue is full shows as a level of 33 or as an extra byte in the drained stream.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Strobes passed from the control unit to the storage
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } txqStrobe_t;

  // Selector code to threshold: 0 -> 1, n -> 2^(n+1)
  function automatic int wmThreshold(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (1 << (int'(code) + 1));
  endfunction

endpackage

// File: rtl/txq_store.sv
module txq_store
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  txqStrobe_t        strb,
  input  logic [DATA_W-1:0] wrByte,
  output logic [DATA_W-1:0] headByte,
  output logic [LVL_W-1:0]  level
);

  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.push) wrPtr <= bump(wrPtr);
      if (strb.pop)  rdPtr <= bump(rdPtr);
      if (strb.push && !strb.pop)      level <= level + 1'b1;
      else if (strb.pop && !strb.push) level <= level - 1'b1;
    end
  end

  assign headByte = mem[rdPtr];

  // R2: the count never exceeds the depth
  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  // R2: a lone push adds exactly one
  a_r2_push_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop && !strb.clear) |=> level == $past(level) + 1'b1);

  // R8: clear rewinds both pointers together
  a_r8_ptr_rewind: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (wrPtr == '0 && rdPtr == '0));

endmodule

// File: rtl/txq_ctrl.sv
module txq_ctrl
  import txq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrStrobe,
  input  logic             txPop,
  input  logic             softClear,
  input  logic [1:0]       wmSel,
  input  logic [LVL_W-1:0] level,
  output txqStrobe_t       strb,
  output logic             fullFlag,
  output logic             emptyFlag,
  output logic             wmFlag,
  output logic             wmEvent,
  output logic             emptyEvent,
  output logic             overflowPulse
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

  logic [LVL_W-1:0] nextLevel;
  logic [LVL_W-1:0] threshold;
  logic             nextWm;

  always_comb begin
    strb.push  = wrStrobe && !fullFlag && !softClear;
    strb.pop   = txPop && !emptyFlag && !softClear;
    strb.clear = softClear;
  end

  always_comb begin
    threshold = LVL_W'(wmThreshold(wmSel));
    if (strb.clear)                    nextLevel = '0;
    else if (strb.push && !strb.pop)   nextLevel = level + 1'b1;
    else if (strb.pop && !strb.push)   nextLevel = level - 1'b1;
    else                               nextLevel = level;

    nextWm = wmFlag;
    if (strb.clear)                                          nextWm = 1'b0;
    else if (strb.push && !strb.pop && nextLevel >= threshold) nextWm = 1'b1;
    else if (strb.pop && !strb.push && nextLevel < threshold)  nextWm = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag      <= 1'b0;
      emptyFlag     <= 1'b1;
      wmFlag        <= 1'b0;
      wmEvent       <= 1'b0;
      emptyEvent    <= 1'b0;
      overflowPulse <= 1'b0;
    end else begin
      fullFlag      <= (nextLevel == FULL_LVL);
      emptyFlag     <= (nextLevel == '0);
      wmFlag        <= nextWm;
      wmEvent       <= nextWm && !wmFlag;
      emptyEvent    <= (nextLevel == '0) && (level != '0);
      overflowPulse <= wrStrobe && fullFlag && !softClear;
    end
  end

  // R3: full flag tracks the stored count
  a_r3_full_tracks_level: assert property (@(posedge clk) disable iff (!rstN)
    fullFlag == (level == FULL_LVL));

  // R4: empty flag tracks the stored count
  a_r4_empty_tracks_level: assert property (@(posedge clk) disable iff (!rstN)
    emptyFlag == (level == '0));

  // R5: a write into a full queue changes nothing and is reported
  a_r5_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (wrStrobe && fullFlag && !txPop && !softClear) |=> (level == FULL_LVL && overflowPulse));

  // R6: the rise event only comes with the flag
  a_r6_event_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    wmEvent |-> wmFlag);

  // R7: an idle cycle never moves the watermark
  a_r7_idle_holds_wm: assert property (@(posedge clk) disable iff (!rstN)
    (!wrStrobe && !txPop && !softClear) |=> $stable(wmFlag));

  // R8: clear empties and drops the watermark
  a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    softClear |=> (level == '0 && emptyFlag && !wmFlag));

endmodule

// File: rtl/uart_tx_queue.sv
module uart_tx_queue
  import txq_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStrobe,
  input  logic [DATA_W-1:0] wrByte,
  input  logic              txPop,
  input  logic              softClear,
  input  logic [1:0]        wmSel,
  output logic [DATA_W-1:0] popData,
  output logic              popValid,
  output logic [LVL_W-1:0]  fillLevel,
  output logic              fullFlag,
  output logic              emptyFlag,
  output logic              wmFlag,
  output logic              wmEvent,
  output logic              emptyEvent,
  output logic              overflowPulse
);

  txqStrobe_t strb;

  txq_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .txPop(txPop),
    .softClear(softClear), .wmSel(wmSel), .level(fillLevel), .strb(strb),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag), .wmFlag(wmFlag),
    .wmEvent(wmEvent), .emptyEvent(emptyEvent), .overflowPulse(overflowPulse)
  );

  txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrByte(wrByte),
    .headByte(popData), .level(fillLevel)
  );

  assign popValid = !emptyFlag;

  // R1: valid head exactly when something is stored
  a_r1_valid_level: assert property (@(posedge clk) disable iff (!rstN)
    popValid == (fillLevel != '0));

endmodule

// File: tb/uart_tx_queue_tb_top.sv
`timescale 1ns/1ps
module uart_tx_queue_tb_top;

  localparam int DEPTH = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStrobe = 1'b0;
  logic [7:0] wrByte = '0;
  logic       txPop = 1'b0;
  logic       softClear = 1'b0;
  logic [1:0] wmSel = '0;
  logic [7:0] popData;
  logic       popValid;
  logic [5:0] fillLevel;
  logic       fullFlag, emptyFlag, wmFlag, wmEvent, emptyEvent, overflowPulse;

  int checks = 0;
  int fails = 0;
  byte unsigned expQ[$];
  int  modLevel = 0;
  bit  modWm = 1'b0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  uart_tx_queue dut_i (
    .clk(clk), .rstN(rstN), .wrStrobe(wrStrobe), .wrByte(wrByte),
    .txPop(txPop), .softClear(softClear), .wmSel(wmSel),
    .popData(popData), .popValid(popValid), .fillLevel(fillLevel),
    .fullFlag(fullFlag), .emptyFlag(emptyFlag), .wmFlag(wmFlag),
    .wmEvent(wmEvent), .emptyEvent(emptyEvent), .overflowPulse(overflowPulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int thr(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (1 << (int'(code) + 1));
  endfunction

  // Monitor: compares each popped byte with the scoreboard (R1)
  always @(posedge clk) begin
    if (rstN && popValid && txPop && !softClear) begin
      if (expQ.size() == 0) chk(1'b0, "R1 pop from empty model", popData, -1);
      else begin
        byte unsigned e;
        e = expQ.pop_front();
        chk(popData == e, "R1 byte order", popData, e);
      end
    end
  end

  // Driver: one clock with the given inputs, then compare every output
  task automatic step(input bit wr, input byte unsigned d, input bit pop,
                      input bit clr, input logic [1:0] sel);
    int  prev;
    bit  prevWm, acc, popped, expOvf;
    wrStrobe = wr; wrByte = d; txPop = pop; softClear = clr; wmSel = sel;
    prev   = modLevel;
    prevWm = modWm;
    acc    = wr && prev < DEPTH && !clr;
    popped = pop && prev > 0 && !clr;
    expOvf = wr && prev == DEPTH && !clr;
    @(posedge clk);
    #1;
    if (clr) begin
      expQ.delete();
      modLevel = 0;
      modWm = 1'b0;
    end else begin
      if (acc) expQ.push_back(d);
      modLevel = prev + (acc ? 1 : 0) - (popped ? 1 : 0);
      if (acc && !popped && modLevel >= thr(sel)) modWm = 1'b1;
      else if (popped && !acc && modLevel < thr(sel)) modWm = 1'b0;
    end
    @(negedge clk);
    wrStrobe = 1'b0; txPop = 1'b0; softClear = 1'b0;
    chk(fillLevel == modLevel, "R2 level", fillLevel, modLevel);
    chk(popValid == (modLevel != 0), "R1 valid", popValid, modLevel != 0);
    chk(fullFlag == (modLevel == DEPTH), "R3 full", fullFlag, modLevel == DEPTH);
    chk(emptyFlag == (modLevel == 0), "R4 empty", emptyFlag, modLevel == 0);
    chk(emptyEvent == (prev != 0 && modLevel == 0), "R4 empty event", emptyEvent,
        prev != 0 && modLevel == 0);
    chk(overflowPulse == expOvf, "R5 overflow", overflowPulse, expOvf);
    chk(wmFlag == modWm, "R6/R7 watermark", wmFlag, modWm);
    chk(wmEvent == (modWm && !prevWm), "R6 wm event", wmEvent, modWm && !prevWm);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(fillLevel == 0, "R9 level", fillLevel, 0);
    chk(emptyFlag == 1, "R9 empty", emptyFlag, 1);
    chk(popValid == 0, "R9 valid", popValid, 0);
    chk({fullFlag, wmFlag, wmEvent, emptyEvent, overflowPulse} == 0, "R9 flags",
        {fullFlag, wmFlag, wmEvent, emptyEvent, overflowPulse}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R6: threshold 4, five writes
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 0, 2'd1);
    // R7: raise threshold with no traffic, flag holds
    step(0, 0, 0, 0, 2'd3);
    chk(wmFlag == 1, "R7 selector change alone", wmFlag, 1);
    // R7/R1/R4: drain at threshold 16
    for (int i = 0; i < 5; i++) step(0, 0, 1, 0, 2'd3);
    chk(emptyFlag == 1, "R4 drained", emptyFlag, 1);

    // R2: simultaneous write and pop
    step(1, 8'hA1, 0, 0, 2'd0);
    step(1, 8'hA2, 1, 0, 2'd0);
    chk(fillLevel == 1, "R2 push+pop keeps level", fillLevel, 1);
    step(0, 0, 1, 0, 2'd0);

    // R3/R5: fill, overflow, then one pop clears full
    for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 0, 0, 2'd2);
    chk(fullFlag == 1, "R3 full at depth", fullFlag, 1);
    step(1, 8'hEE, 0, 0, 2'd2);
    chk(fillLevel == DEPTH, "R5 level held", fillLevel, DEPTH);
    step(1, 8'hEF, 1, 0, 2'd2);
    chk(fullFlag == 0, "R3 full clears after pop", fullFlag, 0);

    // R8: clear with a write in the same cycle
    step(1, 8'hCC, 1, 1, 2'd2);
    chk(fillLevel == 0, "R8 cleared", fillLevel, 0);
    step(1, 8'h5A, 0, 0, 2'd0);
    chk(popData == 8'h5A, "R8 head after clear", popData, 8'h5A);
    step(0, 0, 1, 0, 2'd0);

    // Mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step($urandom_range(0, 99) < 55, 8'($urandom), $urandom_range(0, 99) < 45,
           r == 0, 2'($urandom_range(0, 3)));
    end
    while (modLevel > 0) step(0, 0, 1, 0, 2'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule